// File: doc/BRIEF.md
# Watchdog Countdown and Reset Core

This block is a down-counting watchdog timer. Software gives it a start value. While counting is enabled, the counter steps down by one on every clock. When the counter is found at zero, the block raises an interrupt and starts a fresh period from the stored start value.

If software services the interrupt, the clear also restarts the period. If software does not service it, the next expiry finds the interrupt still pending. In that case the block asserts a sticky system reset, provided the reset path is enabled.

The register interface, write protection and test muxing sit outside this block. The block is driven by plain level and strobe inputs, and all of its state is visible on its outputs.

Top module: `watchdogCore`

## Requirements
- R1: After the asynchronous active-low reset, the stored start value and the count are 0xFFFFFFFF, and the raw interrupt, masked interrupt, interrupt output and reset output are all 0.
- R2: A load strobe stores the load data and puts it into the count on the next clock edge. The load strobe takes priority over every other count update in that cycle.
- R3: While counting is enabled and no load, clear or enable edge occurs, a non-zero count decreases by exactly one per clock.
- R4: While the interrupt enable is low, the count holds its value (apart from loads and clears), and the interrupt output stays 0.
- R5: In the first clock with the interrupt enable high after a clock with it low, the count is reloaded from the stored start value and does not decrement.
- R6: A clear strobe drives the raw interrupt to 0 on the next edge. If no load strobe is present in the same cycle, it also reloads the count from the stored start value.
- R7: An enabled clock that finds the count at zero, with the raw interrupt clear and no load, clear or enable edge, sets the raw interrupt and reloads the count. A start value of N therefore gives N+1 clocks per period.
- R8: An expiry (same conditions as R7) that finds the raw interrupt already set, with the reset enable high, asserts the reset output. The reset output then stays high until the block reset.
- R9: With the reset enable low, an expiry that finds the raw interrupt set leaves the reset output unchanged.
- R10: The masked interrupt equals the raw interrupt ANDed with the interrupt enable, and the interrupt output equals the masked interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadData | input | 32 | New start value |
| loadWr | input | 1 | Strobe: store loadData and restart the count |
| intClr | input | 1 | Strobe: clear the interrupt and reload the count |
| intEn | input | 1 | Level: enables counting and the interrupt |
| resEn | input | 1 | Level: allows the reset output to assert |
| countVal | output | 32 | Current count |
| rawStat | output | 1 | Raw interrupt status |
| maskStat | output | 1 | Masked interrupt status |
| wdInt | output | 1 | Interrupt output |
| wdRes | output | 1 | Sticky reset output |

## Verification
The assertions assume that the load data is never zero, because 1 is the smallest legal start value. They also assume that the strobes are clean single-clock levels that are sampled at the rising edge.

The stimulus respects both assumptions. Every load value, directed or random, is drawn from 1 to 30. All inputs change only on the falling clock edge.

Keeping the start values short lets many expiries happen within a run. As a result, the second-expiry path to the reset output is reached with the reset enable both high and low.

// File: rtl/wdPkg.sv
package wdPkg;
  // Commands from the control unit to the count datapath.
  typedef struct packed {
    logic loadNew;  // store new start value and load it into the count
    logic reload;   // copy stored start value into the count
    logic dec;      // step the count down by one
  } cntCmd_t;
endpackage

// File: rtl/wdDatapath.sv
module wdDatapath
  import wdPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] countVal,
  output logic             countZero
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] startReg;
  logic [CNT_W-1:0] countReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= ALL_ONES;
    end else if (cmd.loadNew) begin
      startReg <= loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= ALL_ONES;
    end else if (cmd.loadNew) begin
      countReg <= loadData;
    end else if (cmd.reload) begin
      countReg <= startReg;
    end else if (cmd.dec) begin
      countReg <= countReg - ONE;
    end
  end

  assign countVal  = countReg;
  assign countZero = (countReg == '0);
endmodule

// File: rtl/wdControl.sv
module wdControl
  import wdPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadWr,
  input  logic    intClr,
  input  logic    intEn,
  input  logic    resEn,
  input  logic    countZero,
  output cntCmd_t cmd,
  output logic    rawInt,
  output logic    resOut
);
  logic enPrev;
  logic enRise;
  logic override;
  logic expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= intEn;
  end

  assign enRise   = intEn & ~enPrev;
  assign override = loadWr | intClr | enRise;
  assign expire   = intEn & countZero & ~override;

  always_comb begin
    cmd         = '0;
    cmd.loadNew = loadWr;
    cmd.reload  = ~loadWr & (intClr | enRise | expire);
    cmd.dec     = intEn & ~countZero & ~override;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawInt <= 1'b0;
    end else if (intClr) begin
      rawInt <= 1'b0;
    end else if (expire) begin
      rawInt <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut <= 1'b0;
    end else if (expire && rawInt && resEn) begin
      resOut <= 1'b1;
    end
  end
endmodule

// File: rtl/watchdogCore.sv
module watchdogCore
  import wdPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] loadData,
  input  logic             loadWr,
  input  logic             intClr,
  input  logic             intEn,
  input  logic             resEn,
  output logic [CNT_W-1:0] countVal,
  output logic             rawStat,
  output logic             maskStat,
  output logic             wdInt,
  output logic             wdRes
);
  cntCmd_t cmd;
  logic    countZero;

  wdControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadWr    (loadWr),
    .intClr    (intClr),
    .intEn     (intEn),
    .resEn     (resEn),
    .countZero (countZero),
    .cmd       (cmd),
    .rawInt    (rawStat),
    .resOut    (wdRes)
  );

  wdDatapath #(.CNT_W(CNT_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .loadData  (loadData),
    .countVal  (countVal),
    .countZero (countZero)
  );

  assign maskStat = rawStat & intEn;
  assign wdInt    = maskStat;
endmodule

// File: rtl/wdChecker.sv
module wdChecker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] loadData,
  input logic             loadWr,
  input logic             intClr,
  input logic             intEn,
  input logic             resEn,
  input logic [CNT_W-1:0] countVal,
  input logic             rawStat,
  input logic             maskStat,
  input logic             wdInt,
  input logic             wdRes
);
  logic enSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enSeen <= 1'b0;
    else       enSeen <= intEn;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> countVal == $past(loadData)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (intEn && enSeen && !loadWr && !intClr && countVal != '0) |=> countVal == $past(countVal) - 1'b1); // R3

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!intEn && !loadWr && !intClr) |=> $stable(countVal)); // R4

  AST_NO_INT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !wdInt); // R4

  AST_CLEAR_RAW: assert property (@(posedge clk) disable iff (!rstN)
    intClr |=> !rawStat); // R6

  AST_RES_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wdRes |=> wdRes); // R8

  AST_RES_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRes) |-> $past(rawStat) && $past(resEn)); // R8

  AST_RES_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!resEn && !wdRes) |=> !wdRes); // R9

  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    wdInt == (rawStat && intEn)); // R10

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |-> loadData != '0); // R2
endmodule

bind watchdogCore wdChecker #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .loadData (loadData),
  .loadWr   (loadWr),
  .intClr   (intClr),
  .intEn    (intEn),
  .resEn    (resEn),
  .countVal (countVal),
  .rawStat  (rawStat),
  .maskStat (maskStat),
  .wdInt    (wdInt),
  .wdRes    (wdRes)
);

// File: tb/tb_watchdogCore.sv
module tb_watchdogCore;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] loadData = 32'd1;
  logic        loadWr = 1'b0;
  logic        intClr = 1'b0;
  logic        intEn = 1'b0;
  logic        resEn = 1'b0;
  logic [31:0] countVal;
  logic        rawStat, maskStat, wdInt, wdRes;

  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  string phase = "R1 reset state";

  // reference model state, built from the requirements
  logic [31:0] mStart, mCnt;
  logic        mPrev, mRaw, mRes;

  always #5 clk = ~clk;

  watchdogCore dut (
    .clk(clk), .rstN(rstN), .loadData(loadData), .loadWr(loadWr),
    .intClr(intClr), .intEn(intEn), .resEn(resEn), .countVal(countVal),
    .rawStat(rawStat), .maskStat(maskStat), .wdInt(wdInt), .wdRes(wdRes)
  );

  function automatic logic [31:0] nextCount(logic [31:0] c, logic [31:0] s,
                                           logic ld, logic [31:0] d, logic clr,
                                           logic en, logic prev);
    if (ld) return d;
    if (clr) return s;
    if (en && !prev) return s;
    if (en) return (c == 0) ? s : c - 1;
    return c;
  endfunction

  function automatic bit expires(logic [31:0] c, logic ld, logic clr,
                                 logic en, logic prev);
    return en && prev && !ld && !clr && c == 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStart <= 32'hFFFF_FFFF; mCnt <= 32'hFFFF_FFFF;
      mPrev <= 1'b0; mRaw <= 1'b0; mRes <= 1'b0;
    end else begin
      mCnt  <= nextCount(mCnt, mStart, loadWr, loadData, intClr, intEn, mPrev);
      mPrev <= intEn;
      if (loadWr) mStart <= loadData;
      if (intClr) mRaw <= 1'b0;
      else if (expires(mCnt, loadWr, intClr, intEn, mPrev)) begin
        if (!mRaw) mRaw <= 1'b1;
        else if (resEn) mRes <= 1'b1;
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("count (R3)", countVal, mCnt);
    check("raw interrupt (R7)", {31'd0, rawStat}, {31'd0, mRaw});
    check("masked status (R10)", {31'd0, maskStat}, {31'd0, mRaw & intEn});
    check("interrupt out (R10)", {31'd0, wdInt}, {31'd0, mRaw & intEn});
    check("reset out (R8)", {31'd0, wdRes}, {31'd0, mRes});
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      loadWr = 1'b0; intClr = 1'b0;
      #1 compareAll();
    end
  endtask

  task automatic doLoad(logic [31:0] v);
    @(negedge clk); loadData = v; loadWr = 1'b1;
    @(negedge clk); loadWr = 1'b0; #1 compareAll();
  endtask

  task automatic doClear();
    @(negedge clk); intClr = 1'b1;
    @(negedge clk); intClr = 1'b0; #1 compareAll();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL [watchdog] run hung: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    #12 compareAll();                                  // R1 during reset
    @(negedge clk); rstN = 1'b1;
    phase = "R1 after reset"; step(3);
    check("R1 count after reset", countVal, 32'hFFFF_FFFF);

    phase = "R2 load while off"; doLoad(32'd5);
    check("R2 count equals load", countVal, 32'd5);
    phase = "R4 hold while off"; step(4);
    check("R4 count held", countVal, 32'd5);

    phase = "R5 enable edge"; @(negedge clk); intEn = 1'b1; step(1);
    check("R5 reload on edge", countVal, 32'd5);
    phase = "R3 counting"; step(3);
    check("R3 count after 3", countVal, 32'd2);
    phase = "R4 disable hold"; @(negedge clk); intEn = 1'b0; step(3);
    check("R4 held at", countVal, 32'd1);
    phase = "R5 re-enable reload"; @(negedge clk); intEn = 1'b1; step(1);
    check("R5 reloaded", countVal, 32'd5);

    phase = "R7 first expiry"; step(6);
    check("R7 raw set", {31'd0, rawStat}, 32'd1);
    phase = "R10 mask off"; @(negedge clk); intEn = 1'b0; step(2);
    check("R10 int masked", {31'd0, wdInt}, 32'd0);
    @(negedge clk); intEn = 1'b1; step(1);
    phase = "R6 clear"; doClear();
    check("R6 raw cleared", {31'd0, rawStat}, 32'd0);
    check("R6 count reloaded", countVal, 32'd5);

    phase = "R9 reset masked"; @(negedge clk); resEn = 1'b0; step(14);
    check("R9 no reset", {31'd0, wdRes}, 32'd0);
    doClear();

    phase = "R8 second expiry"; @(negedge clk); resEn = 1'b1; doLoad(32'd1);
    step(6);
    check("R8 reset asserted", {31'd0, wdRes}, 32'd1);
    @(negedge clk); resEn = 1'b0; intEn = 1'b0; step(3);
    check("R8 reset sticky", {31'd0, wdRes}, 32'd1);

    phase = "R1 re-reset"; @(negedge clk); rstN = 1'b0; #1 compareAll();
    @(negedge clk); rstN = 1'b1; step(1);

    phase = "R3 random mix";
    resEn = $urandom_range(1, 0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      loadWr = ($urandom_range(39, 0) == 0);
      loadData = $urandom_range(30, 1);
      intClr = ($urandom_range(29, 0) == 0);
      if ($urandom_range(49, 0) == 0) intEn = ~intEn;
      if ($urandom_range(999, 0) == 0) resEn = ~resEn;
      #1 compareAll();
    end
    step(1);
    finishRun();
  end
endmodule